// File: doc/BRIEF.md
# Receive Buffer with Watermark Stop/Go Backpressure

This block is one point-to-point link between two switches. It has a small upstream sender, a forward path of fixed latency, a receive FIFO at the far end and a one-bit back-channel. The back-channel is a level: high means halt and low means send. The receiver compares its FIFO occupancy with two programmable levels. It raises halt once occupancy climbs past the upper level. It drops halt once occupancy has drained to the lower level or below. Between the two levels the previous indication is kept, so the link does not chatter.

The back-channel is registered through a parameterised number of stages. The sender obeys only the delayed copy. Because the indication is a level, the same halt or send value arrives at the sender every cycle, and a repeated value changes nothing. The space above the upper level must cover the whole loop latency. Phits already launched when halt is raised then still find room in the FIFO.

Top module: `wlfc_link`

## Requirements
- R1: While reset is held, and until the first phit is offered, `stop_bc` is 0, `src_ready` is 1, `snk_valid` is 0 and `fill` is 0.
- R2: In the cycle after `fill` is greater than `hi_mark`, `stop_bc` is 1.
- R3: In the cycle after `fill` is less than or equal to `lo_mark`, `stop_bc` is 0.
- R4: When `fill` lies above `lo_mark` and at or below `hi_mark`, `stop_bc` keeps its previous value in the next cycle.
- R5: `src_ready` equals the inverse of `stop_bc` as it was BC_LAT cycles earlier. A run of consecutive halt values keeps `src_ready` low for the same run, with no other effect.
- R6: A phit is taken from the source only in a cycle where `src_valid` and `src_ready` are both 1. Phits offered while `src_ready` is 0 never reach the sink. Accepted phits reach the sink in acceptance order with their data unchanged.
- R7: A phit accepted at a clock edge is counted in `fill` after the edge FWD_LAT cycles later. A cycle with both a FIFO write and a sink read leaves `fill` unchanged.
- R8: With `lo_mark` < `hi_mark` <= DEPTH-(FWD_LAT+BC_LAT+2), the FIFO never overflows, even when the sink is stalled and the source is always valid. `fill` then peaks at `hi_mark`+FWD_LAT+BC_LAT+2.
- R9: `snk_valid` is 1 exactly when `fill` is nonzero. `snk_phit` is then the oldest stored phit. A read happens when `snk_valid` and `snk_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| src_valid | input | 1 | Source offers a phit |
| src_phit | input | PHIT_W | Offered phit data |
| src_ready | output | 1 | Sender permitted to launch (delayed send/halt indication) |
| snk_valid | output | 1 | Receive FIFO holds at least one phit |
| snk_phit | output | PHIT_W | Oldest phit in the receive FIFO |
| snk_ready | input | 1 | Sink takes the oldest phit |
| hi_mark | input | $clog2(DEPTH+1) | Upper occupancy level |
| lo_mark | input | $clog2(DEPTH+1) | Lower occupancy level |
| stop_bc | output | 1 | Back-channel level as sent by the receiver (1 = halt) |
| fill | output | $clog2(DEPTH+1) | Receive FIFO occupancy |

## Verification
Two events can land in the same cycle: a FIFO write arriving off the forward path and a sink read. Their effect on occupancy feeds the watermark decision in that same cycle. A second coincidence is a new halt decision while an older, opposite indication is still reaching the sender through the delay stages. Both are provoked by a random source and sink, first with a wide band between the levels and then with the levels one apart, so occupancy crosses a level almost every few cycles. A behavioural model built from queues predicts every output. The model is compared with the design at each falling edge, and each compare is tagged with the rule that governs the expected value.

// File: rtl/wlfc_pkg.sv
`timescale 1ns/1ps
package wlfc_pkg;

  typedef enum logic {
    LINK_SEND = 1'b0,
    LINK_HALT = 1'b1
  } link_cmd_e;

  // Space needed above the upper level: launches still possible after
  // the halt decision plus phits already on the forward path.
  function automatic int unsigned loop_slack(input int unsigned fwd_lat,
                                             input int unsigned bc_lat);
    return fwd_lat + bc_lat + 2;
  endfunction

endpackage

// File: rtl/wlfc_rst_sync.sv
`timescale 1ns/1ps
module wlfc_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/wlfc_delay_line.sv
`timescale 1ns/1ps
module wlfc_delay_line #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb stage_d[g] = d_i;
    end else begin : g_body
      always_comb stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
      end else begin
        stage_q[g] <= stage_d[g];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wlfc_rx_fifo.sv
`timescale 1ns/1ps
module wlfc_rx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] fill_o
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [PTR_W-1:0] wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_en, rd_en;

  always_comb begin
    wr_en = push_i && (cnt_q != FULL_CNT || pop_i);
    rd_en = pop_i && (cnt_q != '0);
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (rd_en) begin
      rd_d = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
    end
    if (wr_en) begin
      wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
    end
    unique case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; only pointers and count do.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_q] <= data_i;
    end
  end

  assign data_o = mem_q[rd_q];
  assign fill_o = cnt_q;

  // R8: a write never meets a full buffer without a matching read
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    push_i |-> (cnt_q != FULL_CNT) || pop_i);

  // R7: occupancy moves by at most one per cycle
  p_fill_step_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
    (cnt_q == $past(cnt_q) - 1'b1));

  // R9: the sink is never offered a read from an empty buffer
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);

endmodule

// File: rtl/wlfc_watermark.sv
`timescale 1ns/1ps
module wlfc_watermark
  import wlfc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SLACK = 7,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             stop_o
);

  localparam logic [CNT_W-1:0] HI_LIMIT = CNT_W'(DEPTH - SLACK);

  link_cmd_e cmd_q, cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (fill_i > hi_i) begin
      cmd_d = LINK_HALT;
    end else if (fill_i <= lo_i) begin
      cmd_d = LINK_SEND;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= LINK_SEND;
    end else begin
      cmd_q <= cmd_d;
    end
  end

  assign stop_o = (cmd_q == LINK_HALT);

  // R2: occupancy past the upper level yields halt next cycle
  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (fill_i > hi_i) |=> stop_o);

  // R3: occupancy at or below the lower level yields send next cycle
  p_go_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (fill_i <= lo_i) |=> !stop_o);

  // R4: between the levels the indication is held
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (fill_i > lo_i && fill_i <= hi_i) |=> $stable(stop_o));

  // R8: level ordering and loop headroom
  p_marks_order_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    lo_i < hi_i);
  p_headroom_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    hi_i <= HI_LIMIT);

endmodule

// File: rtl/wlfc_link.sv
`timescale 1ns/1ps
module wlfc_link
  import wlfc_pkg::*;
#(
  parameter int unsigned PHIT_W  = 8,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned FWD_LAT = 3,
  parameter int unsigned BC_LAT  = 2,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [PHIT_W-1:0] src_phit,
  output logic              src_ready,
  output logic              snk_valid,
  output logic [PHIT_W-1:0] snk_phit,
  input  logic              snk_ready,
  input  logic [CNT_W-1:0]  hi_mark,
  input  logic [CNT_W-1:0]  lo_mark,
  output logic              stop_bc,
  output logic [CNT_W-1:0]  fill
);

  localparam int unsigned SLACK = loop_slack(FWD_LAT, BC_LAT);
  localparam int unsigned LANE_W = PHIT_W + 1;

  logic              rst_int_n;
  logic              halt_seen;
  logic              launch;
  logic [LANE_W-1:0] lane_in, lane_out;
  logic              rx_push;
  logic              rx_pop;
  logic              halt_raw;

  wlfc_rst_sync u_rst (
    .clk        (clk),
    .rst_ni     (rst_n),
    .rst_sync_no(rst_int_n)
  );

  // Sender: launches only while the delayed indication says send.
  always_comb begin
    src_ready = !halt_seen;
    launch    = src_valid && src_ready;
    lane_in   = {launch, src_phit};
  end

  wlfc_delay_line #(.W(LANE_W), .STAGES(FWD_LAT)) u_fwd (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .d_i   (lane_in),
    .q_o   (lane_out)
  );

  assign rx_push   = lane_out[PHIT_W];
  assign snk_valid = (fill != '0);
  assign rx_pop    = snk_valid && snk_ready;

  wlfc_rx_fifo #(.W(PHIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .push_i(rx_push),
    .data_i(lane_out[PHIT_W-1:0]),
    .pop_i (rx_pop),
    .data_o(snk_phit),
    .fill_o(fill)
  );

  wlfc_watermark #(.DEPTH(DEPTH), .SLACK(SLACK)) u_mark (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .fill_i(fill),
    .hi_i  (hi_mark),
    .lo_i  (lo_mark),
    .stop_o(halt_raw)
  );

  assign stop_bc = halt_raw;

  wlfc_delay_line #(.W(1), .STAGES(BC_LAT)) u_back (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .d_i   (halt_raw),
    .q_o   (halt_seen)
  );

  // R6: nothing enters the forward path while the sender is halted
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (src_valid && !src_ready) |=> !u_fwd.stage_q[0][PHIT_W]);

endmodule

// File: tb/wlfc_link_tb_top.sv
`timescale 1ns/1ps
module wlfc_link_tb_top;

  localparam int W     = 8;
  localparam int DEPTH = 16;
  localparam int FWDL  = 3;
  localparam int BCL   = 2;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          src_valid, src_ready, snk_valid, snk_ready, stop_bc;
  logic [W-1:0]  src_phit, snk_phit;
  logic [CW-1:0] hi_mark, lo_mark, fill;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  wlfc_link #(.PHIT_W(W), .DEPTH(DEPTH), .FWD_LAT(FWDL), .BC_LAT(BCL)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_phit(src_phit),
    .src_ready(src_ready), .snk_valid(snk_valid), .snk_phit(snk_phit),
    .snk_ready(snk_ready), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .stop_bc(stop_bc), .fill(fill)
  );

  // Behavioural reference state
  bit           m_stop;
  string        m_stop_tag;
  bit           m_bc[$];
  logic [W:0]   m_fwd[$];
  logic [W-1:0] m_q[$];
  int           pend_hi, pend_lo;
  logic [W-1:0] seq;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int sz = m_q.size();
    chk(stop_bc == m_stop, m_stop_tag, "stop_bc", int'(stop_bc), int'(m_stop));
    chk(src_ready == !m_bc[0], "R5", "src_ready", int'(src_ready), int'(!m_bc[0]));
    chk(int'(fill) == sz, "R7", "fill", int'(fill), sz);
    chk(snk_valid == (sz != 0), "R9", "snk_valid", int'(snk_valid), int'(sz != 0));
    if (sz != 0)
      chk(snk_phit == m_q[0], "R6", "snk_phit", int'(snk_phit), int'(m_q[0]));
  endtask

  // One clock: compare at the falling edge, drive, advance the model.
  task automatic step(input bit v, input bit r);
    bit acc, push, pop, nstop;
    logic [W-1:0] pdata;
    int occ;
    @(negedge clk);
    compare_all();
    hi_mark   = CW'(pend_hi);
    lo_mark   = CW'(pend_lo);
    src_valid = v;
    src_phit  = seq;
    snk_ready = r;
    acc   = v && !m_bc[0];
    push  = m_fwd[0][W];
    pdata = m_fwd[0][W-1:0];
    occ   = m_q.size();
    pop   = (occ > 0) && r;
    if (occ > pend_hi)       begin nstop = 1'b1;   m_stop_tag = "R2"; end
    else if (occ <= pend_lo) begin nstop = 1'b0;   m_stop_tag = "R3"; end
    else                     begin nstop = m_stop; m_stop_tag = "R4"; end
    void'(m_bc.pop_front());
    m_bc.push_back(m_stop);
    m_stop = nstop;
    void'(m_fwd.pop_front());
    m_fwd.push_back({acc, seq});
    if (pop)  void'(m_q.pop_front());
    if (push) m_q.push_back(pdata);
    if (acc)  seq = seq + 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_valid = 1'b0; snk_ready = 1'b0; src_phit = '0;
    pend_hi = 9; pend_lo = 3;
    hi_mark = CW'(pend_hi); lo_mark = CW'(pend_lo);
    seq = '0; m_stop = 1'b0; m_stop_tag = "R1";
    for (int i = 0; i < BCL; i++)  m_bc.push_back(1'b0);
    for (int i = 0; i < FWDL; i++) m_fwd.push_back('0);

    // R1: values while reset is held
    repeat (3) begin
      @(negedge clk);
      chk(stop_bc == 1'b0, "R1", "stop_bc", int'(stop_bc), 0);
      chk(src_ready == 1'b1, "R1", "src_ready", int'(src_ready), 1);
      chk(snk_valid == 1'b0, "R1", "snk_valid", int'(snk_valid), 0);
      chk(fill == '0, "R1", "fill", int'(fill), 0);
    end
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0);

    // R8: saturating source with a stalled sink; peak is exactly DEPTH
    repeat (40) step(1'b1, 1'b0);
    @(negedge clk);
    chk(int'(fill) == DEPTH, "R8", "peak fill", int'(fill), DEPTH);
    chk(src_ready == 1'b0, "R5", "src_ready while halted", int'(src_ready), 0);
    // drain with source still pushing
    repeat (60) step(1'b1, 1'b1);

    // wide band, random traffic
    repeat (1500) step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)));

    // narrow band: levels one apart
    pend_hi = 6; pend_lo = 5;
    repeat (1500) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0));

    // lower level at empty, bursty sink
    pend_hi = 9; pend_lo = 0;
    for (int i = 0; i < 1500; i++)
      step(1'b1, ((i / 20) % 2) == 1);

    repeat (40) step(1'b0, 1'b1);
    @(negedge clk);
    chk(fill == '0, "R6", "drained fill", int'(fill), 0);
    chk(stop_bc == 1'b0, "R3", "stop_bc after drain", int'(stop_bc), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule